// File: doc/BRIEF.md
# Power-Down Freeze and Recovery Controller

This block wraps a small bank of sampled pins and registered logic so that a single dedicated control pin can put the whole region into a quiet, frozen state. While the control pin is high, the sampled copies of the data, clock-enable and output-enable pins stop updating. The internal register keeps its contents. Every output, whether it comes from a register or is computed from the sampled inputs, keeps the value it had at the moment of the freeze. An output that was disabled (high-impedance) stays disabled, and an output that was driving keeps driving its held value.

When the control pin drops, the block does not resume at once. It first counts a recovery window of a configurable number of timebase cycles. Throughout that window the inputs and the clock enable stay blocked and the outputs stay held. If the control pin rises again before the window ends, the block goes straight back to the frozen state with the original held values, and a fresh full window is counted after the next release. A status output reports running, frozen or recovering. A build parameter can switch the feature off entirely. In that case the control pin becomes an ordinary sampled input.

Top module: `pdh_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block resets: `status` becomes 2'b00 and `out_val`, `out_mix`, `out_en` and `pd_aux` become all zeros.
- R2: While running, each edge samples `in_pins`, `ce_pin` and `oe_pins`. The register loads the previously sampled data on any edge where the previously sampled `ce_pin` was 1. `out_val` is the register, `out_mix` is the sampled data XOR the register, and `out_en` is the sampled `oe_pins`.
- R3: `pd_pin` passes through a two-flop synchronizer. The first two rising edges after `pd_pin` rises still sample the pins. From the third edge on, pin changes are ignored.
- R4: While `status` is frozen or recovering, `out_val`, `out_mix` and `out_en` do not change, whatever the pins do. An output whose enable was 0 at the freeze stays disabled.
- R5: `status` encodes running as 2'b00, frozen as 2'b01 and recovering as 2'b10, and never shows 2'b11. After `pd_pin` rises while running, `status` shows frozen from the third rising edge on, and it never passes from running straight to recovering.
- R6: After `pd_pin` falls while frozen, `status` turns to recovering at the third rising edge. It stays there for exactly RECOVER_CYCLES cycles and then returns to running, after which pin changes take effect again.
- R7: A high `pd_pin` during recovery returns `status` to frozen without passing through running. The outputs keep the values held since the first freeze, and the next release counts a full RECOVER_CYCLES window.
- R8: With PD_ENABLE = 0, `status` stays 2'b00, the pins are never blocked, and `pd_aux` is `pd_pin` as sampled at the previous edge. With PD_ENABLE = 1, `pd_aux` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running timebase clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_pin | input | 1 | Power-down control, active high, asynchronous |
| in_pins | input | W | Data input pins |
| ce_pin | input | 1 | Clock-enable pin of the internal register |
| oe_pins | input | W | Per-bit output-enable pins |
| out_val | output | W | Registered output values |
| out_mix | output | W | Combinational output values (sampled data XOR register) |
| out_en | output | W | Per-bit output enables, 0 meaning high-impedance |
| status | output | 2 | 00 running, 01 frozen, 10 recovering |
| pd_aux | output | 1 | Sampled control pin when the feature is disabled, else 0 |

## Verification
The checker assumes the reset is held for at least one edge before any property counts. It assumes the outputs depend only on the sampled pin copies and the register, so a non-running status at one edge implies identical outputs at the next. The recovery-length property relies on a run counter in the checker rather than a deep history, which keeps it valid for any RECOVER_CYCLES. The stimulus toggles `pd_pin` at random intervals, both shorter and longer than the recovery window, and holds it during directed cases, so that freezes, full recoveries and re-entries during recovery all occur.

// File: rtl/pdh_pkg.sv
// Package pdh_pkg
// Shared phase encoding for the power-down freeze controller.
// Assumes: the encoding is visible at the status port, so values are fixed.
package pdh_pkg;
    typedef enum logic [1:0] {
        PH_RUN     = 2'b00,
        PH_FROZEN  = 2'b01,
        PH_RECOVER = 2'b10
    } phase_e;
endpackage

// File: rtl/pdh_sync.sv
// Module pdh_sync
// Multi-flop level synchronizer for the asynchronous power-down pin.
// Assumes: STAGES >= 2; the input is a slow level, not a pulse.
module pdh_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the pin level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pdh_seq.sv
// Module pdh_seq
// Phase sequencer: running, frozen and timed recovery.
// Drives the hold request that blocks sampling and register updates.
// Assumes: RECOVER_CYCLES >= 1; pd_s is already synchronous to clk.
module pdh_seq
    import pdh_pkg::*;
#(
    parameter int RECOVER_CYCLES = 50
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pd_s,
    output phase_e phase,
    output logic   hold
);
    localparam int CNT_W = $clog2(RECOVER_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RECOVER_CYCLES - 1);

    phase_e            phase_nx;
    logic [CNT_W-1:0]  cnt, cnt_nx;

    // Next phase and recovery count from the synchronized pin.
    always_comb begin
        phase_nx = phase;
        cnt_nx   = cnt;
        unique case (phase)
            PH_RUN: begin
                if (pd_s) phase_nx = PH_FROZEN;
            end
            PH_FROZEN: begin
                if (!pd_s) begin
                    phase_nx = PH_RECOVER;
                    cnt_nx   = '0;
                end
            end
            PH_RECOVER: begin
                if (pd_s)              phase_nx = PH_FROZEN;
                else if (cnt == LAST)  phase_nx = PH_RUN;
                else                   cnt_nx   = cnt + 1'b1;
            end
            default: phase_nx = PH_FROZEN;
        endcase
    end

    // Phase and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_RUN;
            cnt   <= '0;
        end else begin
            phase <= phase_nx;
            cnt   <= cnt_nx;
        end
    end

    // Block as soon as the pin is seen, and until recovery ends.
    assign hold = pd_s | (phase != PH_RUN);
endmodule

// File: rtl/pdh_core.sv
// Module pdh_core
// Pin hold latches and the wrapped register bank.
// All outputs derive from latched state, so freezing the latches and the
// register freezes every output, including the enables.
// Assumes: hold is synchronous to clk.
module pdh_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic [W-1:0] in_pins,
    input  logic         ce_pin,
    input  logic [W-1:0] oe_pins,
    input  logic         extra_pin,
    output logic [W-1:0] out_val,
    output logic [W-1:0] out_mix,
    output logic [W-1:0] out_en,
    output logic         extra_q
);
    logic [W-1:0] in_l, oe_l, core_q;
    logic         ce_l, ex_l;

    // Pin hold latches: follow the pins unless held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_l <= '0;
            oe_l <= '0;
            ce_l <= 1'b0;
            ex_l <= 1'b0;
        end else if (!hold) begin
            in_l <= in_pins;
            oe_l <= oe_pins;
            ce_l <= ce_pin;
            ex_l <= extra_pin;
        end
    end

    // Wrapped register: loads latched data on an enabled, unheld edge.
    always_ff @(posedge clk) begin
        if (!rst_n)               core_q <= '0;
        else if (!hold && ce_l)   core_q <= in_l;
    end

    assign out_val = core_q;
    assign out_mix = in_l ^ core_q;
    assign out_en  = oe_l;
    assign extra_q = ex_l;
endmodule

// File: rtl/pdh_ctrl.sv
// Module pdh_ctrl
// Top of the power-down freeze controller. With PD_ENABLE set, the pin is
// synchronized and sequenced into a hold request; otherwise the pin is an
// ordinary sampled input reported on pd_aux.
// Assumes: clk is free running; rst_n is synchronous and active low.
module pdh_ctrl
    import pdh_pkg::*;
#(
    parameter int W              = 8,
    parameter int RECOVER_CYCLES = 50,
    parameter int SYNC_STAGES    = 2,
    parameter bit PD_ENABLE      = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pd_pin,
    input  logic [W-1:0] in_pins,
    input  logic         ce_pin,
    input  logic [W-1:0] oe_pins,
    output logic [W-1:0] out_val,
    output logic [W-1:0] out_mix,
    output logic [W-1:0] out_en,
    output logic [1:0]   status,
    output logic         pd_aux
);
    phase_e phase;
    logic   hold;
    logic   extra_pin;

    generate
        if (PD_ENABLE) begin : g_pd
            logic pd_s;

            pdh_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (pd_pin),
                .q     (pd_s)
            );

            pdh_seq #(.RECOVER_CYCLES(RECOVER_CYCLES)) u_seq (
                .clk   (clk),
                .rst_n (rst_n),
                .pd_s  (pd_s),
                .phase (phase),
                .hold  (hold)
            );

            assign extra_pin = 1'b0;
        end else begin : g_plain
            assign phase     = PH_RUN;
            assign hold      = 1'b0;
            assign extra_pin = pd_pin;
        end
    endgenerate

    pdh_core #(.W(W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (hold),
        .in_pins   (in_pins),
        .ce_pin    (ce_pin),
        .oe_pins   (oe_pins),
        .extra_pin (extra_pin),
        .out_val   (out_val),
        .out_mix   (out_mix),
        .out_en    (out_en),
        .extra_q   (pd_aux)
    );

    assign status = phase;
endmodule

// File: rtl/pdh_ctrl_chk.sv
// Module pdh_ctrl_chk
// Property checker bound to pdh_ctrl; observes ports only.
// Assumes: reset held for at least one edge at start.
module pdh_ctrl_chk #(
    parameter int W              = 8,
    parameter int RECOVER_CYCLES = 50
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   status,
    input logic [W-1:0] out_val,
    input logic [W-1:0] out_mix,
    input logic [W-1:0] out_en
);
    localparam int RW = $clog2(RECOVER_CYCLES + 2);
    localparam logic [RW-1:0] LIM  = RW'(RECOVER_CYCLES);
    localparam logic [RW-1:0] LAST = RW'(RECOVER_CYCLES - 1);

    logic [RW-1:0] rec_run;

    // Count consecutive recovering cycles seen so far.
    always_ff @(posedge clk) begin
        if (!rst_n)               rec_run <= '0;
        else if (status == 2'b10) rec_run <= rec_run + 1'b1;
        else                      rec_run <= '0;
    end

    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status != 2'b00) |=> ($stable(out_val) && $stable(out_mix) && $stable(out_en)));

    // R5
    status_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status != 2'b11);

    // R5
    run_no_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'b00) |=> (status != 2'b10));

    // R7
    no_skip_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'b01) |=> (status != 2'b00));

    // R6
    recover_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'b10) |-> (rec_run < LIM));

    // R6
    no_early_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'b10 && rec_run != LAST) |=> (status != 2'b00));
endmodule

bind pdh_ctrl pdh_ctrl_chk #(.W(W), .RECOVER_CYCLES(RECOVER_CYCLES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .status  (status),
    .out_val (out_val),
    .out_mix (out_mix),
    .out_en  (out_en)
);

// File: tb/pdh_ctrl_test.sv
module pdh_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int W    = 8;
    localparam int NREC = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pd = 1'b0;
    logic [W-1:0] in_p = '0, oe_p = '0;
    logic         ce_p = 1'b0;

    logic [W-1:0] o_val, o_mix, o_en, f_val, f_mix, f_en;
    logic [1:0]   o_st, f_st;
    logic         o_aux, f_aux;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit cmp_on = 1'b0, done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pdh_ctrl #(.W(W), .RECOVER_CYCLES(NREC), .PD_ENABLE(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .pd_pin(pd), .in_pins(in_p), .ce_pin(ce_p),
        .oe_pins(oe_p), .out_val(o_val), .out_mix(o_mix), .out_en(o_en),
        .status(o_st), .pd_aux(o_aux));

    pdh_ctrl #(.W(W), .RECOVER_CYCLES(NREC), .PD_ENABLE(1'b0)) uut_off (
        .clk(clk), .rst_n(rst_n), .pd_pin(pd), .in_pins(in_p), .ce_pin(ce_p),
        .oe_pins(oe_p), .out_val(f_val), .out_mix(f_mix), .out_en(f_en),
        .status(f_st), .pd_aux(f_aux));

    // Reference model built from the requirements
    logic         m_s1, m_s2, m_cl, f_cl, f_px;
    logic [1:0]   m_st;
    int           m_cnt;
    logic [W-1:0] m_il, m_ol, m_cq, f_il, f_ol, f_cq;
    wire          m_hold = m_s2 | (m_st != 2'b00);

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_st <= 2'b00; m_cnt <= 0;
            m_il <= '0; m_ol <= '0; m_cl <= 0; m_cq <= '0;
            f_il <= '0; f_ol <= '0; f_cl <= 0; f_cq <= '0; f_px <= 0;
        end else begin
            m_s1 <= pd; m_s2 <= m_s1;
            if (!m_hold) begin
                m_il <= in_p; m_ol <= oe_p; m_cl <= ce_p;
                if (m_cl) m_cq <= m_il;
            end
            case (m_st)
                2'b00: if (m_s2) m_st <= 2'b01;
                2'b01: if (!m_s2) begin m_st <= 2'b10; m_cnt <= 0; end
                default: begin
                    if (m_s2) m_st <= 2'b01;
                    else if (m_cnt == NREC-1) m_st <= 2'b00;
                    else m_cnt <= m_cnt + 1;
                end
            endcase
            f_il <= in_p; f_ol <= oe_p; f_cl <= ce_p; f_px <= pd;
            if (f_cl) f_cq <= f_il;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            if (m_st == 2'b00 && !m_s2) begin
                chk("R2 out_val", o_val, m_cq);
                chk("R2 out_mix", o_mix, m_il ^ m_cq);
                chk("R2 out_en", o_en, m_ol);
            end else begin
                chk("R4 out_val", o_val, m_cq);
                chk("R4 out_mix", o_mix, m_il ^ m_cq);
                chk("R4 out_en", o_en, m_ol);
            end
            chk("R5 status", o_st, m_st);
            chk("R8 aux enabled", o_aux, 0);
            chk("R8 off status", f_st, 0);
            chk("R8 off aux", f_aux, f_px);
            chk("R8 off val", f_val, f_cq);
            chk("R8 off mix", f_mix, f_il ^ f_cq);
            chk("R8 off en", f_en, f_ol);
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            finish_run();
        end
    end

    task automatic wait_status(input logic [1:0] s);
        for (int k = 0; k < 500; k++) begin
            @(negedge clk);
            if (o_st == s) break;
        end
    endtask

    initial begin
        logic [W-1:0] a, b, sv, sm, se, e;
        int cnt, seed;
        bit saw_run;
        seed = $urandom(32'h1d5a_0c3e);
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 status", o_st, 2'b00);
        chk("R1 out_val", o_val, 0);
        chk("R1 out_mix", o_mix, 0);
        chk("R1 out_en", o_en, 0);
        chk("R1 pd_aux", f_aux, 0);
        rst_n = 1'b1;
        cmp_on = 1'b1;

        // Random phase: pins and power-down toggles, checked by model
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            in_p = W'($urandom); oe_p = W'($urandom); ce_p = 1'($urandom);
            if ($urandom % 23 == 0) pd = ~pd;
        end

        // R3/R5 entry latency and snapshot
        pd = 0;
        wait_status(2'b00);
        repeat (5) @(negedge clk);
        a = 8'h3c; b = 8'hc5;
        in_p = a; oe_p = 8'h0f; ce_p = 1; pd = 1;
        @(negedge clk);
        in_p = b; oe_p = 8'hf0;
        @(negedge clk);
        chk("R5 still running after edge 2", o_st, 2'b00);
        in_p = 8'h77; oe_p = 8'hff;
        @(negedge clk);
        chk("R5 frozen after edge 3", o_st, 2'b01);
        chk("R3 held out_val", o_val, a);
        chk("R3 held out_mix", o_mix, a ^ b);
        chk("R3 held out_en", o_en, 8'hf0);
        // R4 pins ignored while frozen; disabled bits stay disabled
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            in_p = W'($urandom); oe_p = 8'hff; ce_p = 1;
            chk("R4 frozen en", o_en, 8'hf0);
            chk("R4 frozen val", o_val, a);
        end

        // R6 release and recovery length
        pd = 0;
        @(negedge clk); chk("R6 frozen edge 1", o_st, 2'b01);
        @(negedge clk); chk("R6 frozen edge 2", o_st, 2'b01);
        @(negedge clk); chk("R6 recovering edge 3", o_st, 2'b10);
        cnt = 1;
        for (int k = 0; k < 1000; k++) begin
            @(negedge clk);
            if (o_st == 2'b10) cnt++; else break;
        end
        chk("R6 recovery length", cnt, NREC);
        chk("R6 back to running", o_st, 2'b00);
        chk("R6 held through recovery", o_val, a);
        e = 8'h5a; in_p = e; ce_p = 1;
        repeat (2) @(negedge clk);
        chk("R6 pins take effect", o_val, e);

        // R7 re-entry during recovery
        pd = 1;
        wait_status(2'b01);
        sv = o_val; sm = o_mix; se = o_en;
        pd = 0;
        wait_status(2'b10);
        repeat (4) @(negedge clk);
        pd = 1;
        saw_run = 0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            in_p = W'($urandom);
            if (o_st == 2'b00) saw_run = 1;
            if (o_st == 2'b01) break;
        end
        chk("R7 no run on re-entry", saw_run, 0);
        chk("R7 refrozen", o_st, 2'b01);
        chk("R7 val kept", o_val, sv);
        chk("R7 mix kept", o_mix, sm);
        chk("R7 en kept", o_en, se);
        pd = 0;
        wait_status(2'b10);
        cnt = 1;
        for (int k = 0; k < 1000; k++) begin
            @(negedge clk);
            if (o_st == 2'b10) cnt++; else break;
        end
        chk("R7 full window after re-entry", cnt, NREC);

        // R8 disabled variant follows pins while pd high
        pd = 1; oe_p = 8'h96;
        @(negedge clk);
        chk("R8 off en follows", f_en, 8'h96);
        chk("R8 off aux", f_aux, 1);
        chk("R8 off status", f_st, 0);
        repeat (5) @(negedge clk);
        pd = 0;
        repeat (30) @(negedge clk);

        done = 1'b1;
        finish_run();
    end
endmodule